// File: doc/BRIEF.md
# Feedback Divider with Phase-Step Injection

This block is the programmable feedback divider of an integer-N PLL. It runs on the VCO clock and counts upward from 0 to the active divisor minus one, then wraps. It drives the feedback clock from that count: high for the lower half of the period and low for the upper half. The same count is also an output, so measurement logic can sample where the feedback phase stands in a given VCO cycle.

On request, the divider swaps in a modified divisor for exactly one feedback period and then goes back to the nominal divisor. This shifts the feedback phase by a known number of VCO cycles. The shift is later in time when the divisor is lengthened and earlier when it is shortened. After the modified period ends, a one-cycle completion pulse starts the measurement logic. A synchronizer chain brings the asynchronous reference clock into the VCO domain, and two single-cycle pulses mark its rising and falling edges.

The step sequencer is a five-state machine:
- ARMED waits for a request. When one arrives it goes to PENDING and latches the step size and direction.
- PENDING waits for the next wrap. At that wrap the modified divisor is loaded and the machine goes to STEPPING.
- STEPPING waits for the wrap that ends the modified period. At that wrap the nominal divisor is reloaded and the machine goes to DONE.
- DONE lasts one cycle and raises the completion pulse, then goes to REARM.
- REARM waits for the request to be seen low, then goes back to ARMED.

Top module: `fbdiv_step_top`

## Requirements
- R1: While reset is asserted and on release, the count is 0, the active divisor is 8, the feedback clock is high, and the step-done, reference-rise and reference-fall pulses are low. The first feedback period after reset lasts 8 VCO cycles, whatever the nominal divisor input holds.
- R2: The count increases by one on every VCO clock. In the cycle after it reaches the active divisor minus one, it reads 0. One feedback period therefore lasts as many VCO cycles as the active divisor.
- R3: The nominal divisor input is taken as 5 whenever it holds a value below 5; its 6-bit range reaches 63. A change to the nominal divisor takes effect only at the next wrap of the count.
- R4: The feedback clock is 1 while the count is below floor(active divisor / 2) and 0 otherwise.
- R5: The step direction input selects the shift. With step direction 0 (retard), the first full period after an accepted request lasts nominal + K VCO cycles, where K is the 6-bit step size, limited to at most 63.
- R6: With step direction 1 (advance), the modified period lasts nominal − K VCO cycles, limited to at least 2.
- R7: Exactly one period is modified. The period that follows lasts the nominal divisor again.
- R8: Step-done is high for exactly one VCO cycle. That cycle is the first cycle of the period after the modified one, so the count reads 0.
- R9: The step size and step direction are sampled in the cycle the request is accepted. Changes to them after acceptance do not alter that step.
- R10: Only one step is made per arming. While the request stays high after a step completes, no further step occurs. A new request is accepted only after the request has been seen low for at least one cycle.
- R11: With two synchronizer stages, a reference-clock rising edge set up before VCO edge n raises the reference-rise pulse for exactly the one cycle after edge n+1. The falling edge behaves the same way on the reference-fall pulse. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock, asynchronous to vco_clk |
| div_nom | input | 6 | Nominal divisor; values below 5 are treated as 5 |
| step_size | input | 6 | Phase step K in VCO cycles |
| step_dir | input | 1 | 0 retards the feedback clock, 1 advances it |
| step_req | input | 1 | Level request for a single phase step |
| fb_clk | output | 1 | Feedback clock |
| fb_count | output | 6 | Current divider count |
| ref_rise | output | 1 | One-cycle pulse on a synchronized reference rising edge |
| ref_fall | output | 1 | One-cycle pulse on a synchronized reference falling edge |
| step_done | output | 1 | One-cycle pulse after the modified period ends |

## Verification
The hardest situation to create from the ports is a request whose operands change after it has been accepted but before the modified period starts. Its effect appears only a full period later, as a period length. The stimulus accepts a retard request of 3 and, one cycle later while the machine is still waiting for the wrap, switches the inputs to an advance of 7. The test then measures the period that ends on the step-done pulse. A second hard case is a request held high across completion: the bench keeps it asserted through several nominal periods, then drops it and raises it again to show that arming returns.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    typedef enum logic [2:0] {
        ST_ARMED    = 3'd0,
        ST_PENDING  = 3'd1,
        ST_STEPPING = 3'd2,
        ST_DONE     = 3'd3,
        ST_REARM    = 3'd4
    } step_state_t;

endpackage

// File: rtl/ref_sync_edge.sv
module ref_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic rise_pulse,
    output logic fall_pulse
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              synced;

    generate
        if (STAGES < 2) begin : g_bad_stages
            initial $error("ref_sync_edge needs at least two stages");
        end
    endgenerate

    assign synced = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ref_async};
            last_q  <= synced;
        end
    end

    always_comb begin
        rise_pulse = synced & ~last_q;
        fall_pulse = ~synced & last_q;
    end

    // R11: the edge pulses are mutually exclusive
    a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_pulse && fall_pulse));

    // R11: a rise pulse never lasts two cycles
    a_r11_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/fb_counter.sv
module fb_counter #(
    parameter int CNT_W     = 6,
    parameter int RESET_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_div,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] active_div,
    output logic             at_term,
    output logic             fb_clk
);

    logic [CNT_W-1:0] half_div;

    assign at_term  = (count == (active_div - CNT_W'(1)));
    assign half_div = active_div >> 1;
    assign fb_clk   = (count < half_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            active_div <= CNT_W'(RESET_DIV);
        end else if (at_term) begin
            count      <= '0;
            active_div <= next_div;
        end else begin
            count      <= count + CNT_W'(1);
        end
    end

    // R2: the count advances by one away from the wrap
    a_r2_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !at_term |=> (count == $past(count) + CNT_W'(1)));

    // R2: the count returns to zero after the terminal value
    a_r2_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        at_term |=> (count == '0));

    // R6: a loaded divisor never drops below two
    a_r6_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        active_div >= CNT_W'(2));

endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
    import fbdiv_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int MIN_MOD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_req,
    input  logic [CNT_W-1:0] step_size,
    input  logic             step_dir,
    input  logic             at_term,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] nom_div,
    output logic [CNT_W-1:0] next_div,
    output logic             step_done
);

    localparam int W1      = CNT_W + 1;
    localparam int MAX_DIV = (1 << CNT_W) - 1;

    step_state_t      state_q, state_d;
    logic [CNT_W-1:0] k_q;
    logic             dir_q;
    logic [W1-1:0]    sum_w;
    logic [W1-1:0]    floor_w;
    logic [CNT_W-1:0] mod_div;
    logic             accept;

    assign accept = (state_q == ST_ARMED) && step_req;

    always_comb begin
        sum_w   = {1'b0, nom_div} + {1'b0, k_q};
        floor_w = {1'b0, k_q} + W1'(MIN_MOD);
        if (!dir_q) begin
            if (sum_w > W1'(MAX_DIV)) mod_div = CNT_W'(MAX_DIV);
            else                      mod_div = sum_w[CNT_W-1:0];
        end else begin
            if ({1'b0, nom_div} < floor_w) mod_div = CNT_W'(MIN_MOD);
            else                           mod_div = nom_div - k_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            k_q     <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                k_q   <= step_size;
                dir_q <= step_dir;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:    if (step_req) state_d = ST_PENDING;
            ST_PENDING:  if (at_term)  state_d = ST_STEPPING;
            ST_STEPPING: if (at_term)  state_d = ST_DONE;
            ST_DONE:                   state_d = ST_REARM;
            ST_REARM:    if (!step_req) state_d = ST_ARMED;
            default:                   state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        next_div  = nom_div;
        step_done = 1'b0;
        unique case (state_q)
            ST_PENDING: next_div  = mod_div;
            ST_DONE:    step_done = 1'b1;
            default:    ;
        endcase
    end

    // R8: completion coincides with the first cycle of a new period
    a_r8_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> (count == '0));

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    // R10: a held request cannot leave the rearm state
    a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REARM && step_req) |=> (state_q == ST_REARM));

    // R9: latched operands stay put outside the armed state
    a_r9_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ARMED) |=> ($stable(k_q) && $stable(dir_q)));

endmodule

// File: rtl/fbdiv_step_top.sv
module fbdiv_step_top #(
    parameter int CNT_W       = 6,
    parameter int MIN_NOM     = 5,
    parameter int MIN_MOD     = 2,
    parameter int RESET_DIV   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             vco_clk,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic [CNT_W-1:0] div_nom,
    input  logic [CNT_W-1:0] step_size,
    input  logic             step_dir,
    input  logic             step_req,
    output logic             fb_clk,
    output logic [CNT_W-1:0] fb_count,
    output logic             ref_rise,
    output logic             ref_fall,
    output logic             step_done
);

    logic [CNT_W-1:0] nom_eff;
    logic [CNT_W-1:0] next_div;
    logic [CNT_W-1:0] active_div;
    logic             at_term;

    assign nom_eff = (div_nom < CNT_W'(MIN_NOM)) ? CNT_W'(MIN_NOM) : div_nom;

    fb_counter #(
        .CNT_W     (CNT_W),
        .RESET_DIV (RESET_DIV)
    ) u_counter (
        .clk        (vco_clk),
        .rst_n      (rst_n),
        .next_div   (next_div),
        .count      (fb_count),
        .active_div (active_div),
        .at_term    (at_term),
        .fb_clk     (fb_clk)
    );

    step_ctrl #(
        .CNT_W   (CNT_W),
        .MIN_MOD (MIN_MOD)
    ) u_ctrl (
        .clk       (vco_clk),
        .rst_n     (rst_n),
        .step_req  (step_req),
        .step_size (step_size),
        .step_dir  (step_dir),
        .at_term   (at_term),
        .count     (fb_count),
        .nom_div   (nom_eff),
        .next_div  (next_div),
        .step_done (step_done)
    );

    ref_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (vco_clk),
        .rst_n      (rst_n),
        .ref_async  (ref_clk),
        .rise_pulse (ref_rise),
        .fall_pulse (ref_fall)
    );

    // R3: a divisor change only lands on a wrap
    a_r3_div_at_wrap: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (fb_count != '0) |-> $stable(active_div));

endmodule

// File: tb/fbdiv_step_top_test.sv
module fbdiv_step_top_test;

    logic       vco_clk = 1'b0;
    logic       rst_n;
    logic       ref_clk;
    logic [5:0] div_nom;
    logic [5:0] step_size;
    logic       step_dir;
    logic       step_req;
    logic       fb_clk;
    logic [5:0] fb_count;
    logic       ref_rise;
    logic       ref_fall;
    logic       step_done;

    int n_checks = 0;
    int n_fail   = 0;

    // monitor state
    int run_len     = 0;
    int last_len    = 0;
    int periods     = 0;
    int done_events = 0;
    int done_high   = 0;
    int done_len    = 0;

    // {nominal in, K, dir, effective nominal, modified period}
    localparam int VEC [8][5] = '{
        '{ 8,  3, 0,  8, 11},
        '{ 8,  3, 1,  8,  5},
        '{20,  5, 0, 20, 25},
        '{62,  4, 0, 62, 63},
        '{ 6,  5, 1,  6,  2},
        '{63, 10, 1, 63, 53},
        '{ 3,  2, 0,  5,  7},
        '{10,  0, 0, 10, 10}
    };

    always #10 vco_clk = ~vco_clk;

    fbdiv_step_top uut (
        .vco_clk   (vco_clk),
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .div_nom   (div_nom),
        .step_size (step_size),
        .step_dir  (step_dir),
        .step_req  (step_req),
        .fb_clk    (fb_clk),
        .fb_count  (fb_count),
        .ref_rise  (ref_rise),
        .ref_fall  (ref_fall),
        .step_done (step_done)
    );

    always @(negedge vco_clk) begin
        if (!rst_n) begin
            run_len = 1;
        end else begin
            if (step_done) done_high++;
            if (fb_count == 6'd0) begin
                if (step_done) begin
                    done_len = run_len;
                    done_events++;
                end
                last_len = run_len;
                run_len  = 1;
                periods++;
            end else begin
                run_len++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge vco_clk);
            #1;
        end
    endtask

    task automatic wait_periods(input int n);
        int p0 = periods;
        for (int t = 0; t < 2000 && periods < p0 + n; t++) tick(1);
    endtask

    task automatic wait_done(output bit seen);
        int d0 = done_events;
        seen = 1'b0;
        for (int t = 0; t < 600 && !seen; t++) begin
            tick(1);
            if (done_events > d0) seen = 1'b1;
        end
    endtask

    task automatic pulse_req(input int hold);
        step_req = 1'b1;
        tick(hold);
        step_req = 1'b0;
    endtask

    initial begin
        bit seen;
        int d0;
        int bad;
        int p0;
        rst_n     = 1'b0;
        ref_clk   = 1'b0;
        div_nom   = 6'd12;
        step_size = 6'd0;
        step_dir  = 1'b0;
        step_req  = 1'b0;
        tick(3);

        // R1: reset state
        check(fb_count == 6'd0 && fb_clk && !step_done && !ref_rise && !ref_fall,
              "R1 reset outputs", {fb_count, fb_clk, step_done}, 8'b0000_0010);
        rst_n = 1'b1;
        wait_periods(1);
        check(last_len == 8, "R1 first period uses reset divisor", last_len, 8);
        wait_periods(1);
        check(last_len == 12, "R3 nominal applied at wrap", last_len, 12);

        // table walk: R3 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            div_nom   = 6'(VEC[i][0]);
            step_size = 6'(VEC[i][1]);
            step_dir  = VEC[i][2][0];
            tick(140);
            wait_periods(1);
            check(last_len == VEC[i][3], "R3 nominal period", last_len, VEC[i][3]);
            pulse_req(3);
            wait_done(seen);
            check(seen && done_len == VEC[i][4],
                  VEC[i][2] != 0 ? "R6 advanced period" : "R5 retarded period",
                  done_len, VEC[i][4]);
            check(fb_count == 6'd0 && step_done, "R8 done on first cycle of new period",
                  fb_count, 0);
            wait_periods(1);
            check(last_len == VEC[i][3], "R7 nominal restored", last_len, VEC[i][3]);
        end
        check(done_high == done_events, "R8 done one cycle wide", done_high, done_events);

        // R2: count walk across one full period at divisor 9
        div_nom = 6'd9;
        tick(140);
        wait_periods(1);
        bad = 0;
        for (int c = 0; c < 9; c++) begin
            if (fb_count != 6'(c)) bad++;
            tick(1);
        end
        check(bad == 0, "R2 count sequence 0..8", bad, 0);

        // R4: duty for divisors 8 and 7
        for (int v = 7; v <= 8; v++) begin
            div_nom = 6'(v);
            tick(140);
            bad = 0;
            for (int c = 0; c < 2 * v; c++) begin
                if (fb_clk != (int'(fb_count) < v / 2)) bad++;
                tick(1);
            end
            check(bad == 0, "R4 feedback clock high in lower half", bad, 0);
        end

        // R9: operands changed after acceptance
        div_nom   = 6'd8;
        step_size = 6'd3;
        step_dir  = 1'b0;
        tick(140);
        step_req = 1'b1;
        tick(1);
        step_req  = 1'b0;
        step_size = 6'd7;
        step_dir  = 1'b1;
        wait_done(seen);
        check(seen && done_len == 11, "R9 latched operands used", done_len, 11);

        // R10: held request gives only one step
        step_size = 6'd2;
        step_dir  = 1'b0;
        tick(20);
        step_req = 1'b1;
        wait_done(seen);
        check(seen && done_len == 10, "R10 first step while held", done_len, 10);
        d0 = done_events;
        p0 = periods;
        wait_periods(4);
        check(done_events == d0, "R10 no repeat while held", done_events, d0);
        check(last_len == 8, "R10 periods stay nominal while held", last_len, 8);
        step_req = 1'b0;
        tick(2);
        pulse_req(2);
        wait_done(seen);
        check(seen && done_events == d0 + 1, "R10 rearmed after release", done_events, d0 + 1);

        // R11: synchronized reference edges
        ref_clk = 1'b1;
        tick(1);
        check(!ref_rise, "R11 no rise after one edge", ref_rise, 0);
        tick(1);
        check(ref_rise && !ref_fall, "R11 rise after two edges", ref_rise, 1);
        tick(1);
        check(!ref_rise, "R11 rise lasts one cycle", ref_rise, 0);
        ref_clk = 1'b0;
        tick(1);
        check(!ref_fall, "R11 no fall after one edge", ref_fall, 0);
        tick(1);
        check(ref_fall && !ref_rise, "R11 fall after two edges", ref_fall, 1);
        tick(1);
        check(!ref_fall, "R11 fall lasts one cycle", ref_fall, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge vco_clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule